// File: doc/BRIEF.md
# Triggered Pattern Load Sequencer

This block paces a spatial light modulator's pattern loader. A free-running interval timer emits a one-cycle trigger pulse at a programmable period. Each trigger that finds the sequencer idle starts one pass with three steps. First, a load engine is started and the sequencer waits for its done pulse. Second, a reset engine is started so the new pattern appears, and the sequencer waits for its done pulse. Third, an optional exposure hold runs before the sequencer returns to idle.

The exposure hold is not counted in raw clocks. It is counted in row cycles, and the length of a row cycle depends on the attached device type: 20 clocks for one type and 32 for the other. A trigger that lands while a pass is still running is dropped and recorded in a sticky flag. Because of this, the spacing between passes is always a whole number of trigger intervals. Lengthening the exposure has no effect on pattern rate until the whole pass no longer fits inside the current multiple of the interval.

Configuration arrives through a small write-only register port. The load and reset engines are modelled as start/done pulse pairs.

Top module: `pattern_seq_top`

## Requirements
- R1: The phase output encodes IDLE=0, LOAD=1, RESET=2, EXPOSE=3. The only legal moves are IDLE→LOAD, LOAD→RESET, RESET→EXPOSE, RESET→IDLE and EXPOSE→IDLE. IDLE is left only on a trigger pulse. LOAD is left only on load_done, and RESET only on reset_done.
- R2: load_start is high for exactly the first cycle of each LOAD phase, which is the cycle after the accepted trigger. reset_start is high for exactly the first cycle of each RESET phase, which is the cycle after load_done.
- R3: The exposure count resets to 0. With a count of 0, the sequencer goes from RESET straight to IDLE on reset_done and never shows EXPOSE.
- R4: With an exposure count E ≥ 1, the EXPOSE phase lasts exactly E×20 cycles when device-type bit 0 is 0, and E×32 cycles when it is 1.
- R5: With interval value N ≥ 1, the trigger generator fires once every N cycles. The first pulse comes in the N-th cycle after reset release or after a write to the interval register, because such a write restarts the count. A value of 0 acts as 1, so the generator fires every cycle. The reset default is 50000.
- R6: A trigger that arrives while phase ≠ IDLE is dropped, not queued. The time between successive load_start pulses is therefore the smallest multiple of N that is longer than the pass duration.
- R7: missed_trig is set in the cycle after a dropped trigger and stays set. It is cleared by writing a value with bit 0 = 1 to address 3. Writing bit 0 = 0 has no effect. If a set and a clear happen in the same cycle, the set wins.
- R8: busy is high exactly when phase ≠ IDLE.
- R9: While rst is high on a clock edge, phase returns to IDLE, every output goes low, the counters clear, and the registers return to their defaults: exposure 0, device type 0, interval 50000.
- R10: Register writes take effect on the next cycle. The address map is: address 0 holds the exposure count (wdata[15:0], upper bits ignored); address 1 holds the interval (wdata[31:0]); address 2 holds the device type (wdata[0]); address 3 is the missed-trigger clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| load_done | input | 1 | One-cycle done pulse from the load engine |
| reset_done | input | 1 | One-cycle done pulse from the reset engine |
| load_start | output | 1 | One-cycle start pulse to the load engine |
| reset_start | output | 1 | One-cycle start pulse to the reset engine |
| busy | output | 1 | A pass is in progress |
| phase | output | 2 | Current phase code |
| missed_trig | output | 1 | Sticky dropped-trigger flag |

## Verification
A wrong prescaler or row count shows up as an EXPOSE phase that is a few clocks too short or too long. It appears on the phase port at the end of the first exposure after the fault, and the per-cycle comparison against the reference model catches it in that cycle. A trigger counter that is off by one shifts the first load_start, and the mismatch shows within one interval of reset or of an interval write. A bad accept/drop decision changes the load_start spacing away from a multiple of the interval, or leaves missed_trig wrong in the cycle after the colliding trigger.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOAD   = 2'd1,
    PH_RESET  = 2'd2,
    PH_EXPOSE = 2'd3
  } phase_e;

  localparam logic [1:0] A_EXPOSE   = 2'd0;
  localparam logic [1:0] A_INTERVAL = 2'd1;
  localparam logic [1:0] A_DEVICE   = 2'd2;
  localparam logic [1:0] A_STATUS   = 2'd3;

  // clocks per row cycle for the selected device type
  function automatic int unsigned row_cycles(input logic dev_b,
                                             input int unsigned len_a,
                                             input int unsigned len_b);
    return dev_b ? len_b : len_a;
  endfunction
endpackage

// File: rtl/pseq_regs.sv
module pseq_regs #(
  parameter int          EXP_W  = 16,
  parameter int          IVAL_W = 32,
  parameter int unsigned DEF_IVAL = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  output logic [EXP_W-1:0]  exp_q,
  output logic [IVAL_W-1:0] ival_q,
  output logic              dev_q,
  output logic              ival_wr,
  output logic              clr_missed,
  output logic              exp_zero
);
  import pseq_pkg::*;

  localparam logic [IVAL_W-1:0] IVAL_RST = IVAL_W'(DEF_IVAL);

  assign ival_wr    = we && (addr == A_INTERVAL);
  assign clr_missed = we && (addr == A_STATUS) && wdata[0];
  assign exp_zero   = (exp_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= '0;
      ival_q <= IVAL_RST;
      dev_q  <= 1'b0;
    end else if (we) begin
      case (addr)
        A_EXPOSE:   exp_q  <= wdata[EXP_W-1:0];
        A_INTERVAL: ival_q <= wdata[IVAL_W-1:0];
        A_DEVICE:   dev_q  <= wdata[0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pseq_trig_gen.sv
module pseq_trig_gen #(
  parameter int IVAL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [IVAL_W-1:0] interval,
  output logic              fire
);
  localparam logic [IVAL_W-1:0] ONE = IVAL_W'(1);

  // a zero interval behaves as one
  function automatic logic [IVAL_W-1:0] eff_limit(input logic [IVAL_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [IVAL_W-1:0] cnt_q;
  logic [IVAL_W-1:0] lim;

  assign lim  = eff_limit(interval);
  assign fire = (cnt_q == lim - ONE);

  always_ff @(posedge clk) begin
    if (rst || restart || fire) cnt_q <= '0;
    else                        cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/pseq_expose_timer.sv
module pseq_expose_timer #(
  parameter int EXP_W = 16,
  parameter int ROW_A = 20,
  parameter int ROW_B = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             dev_b,
  input  logic [EXP_W-1:0] exp_count,
  output logic             last
);
  import pseq_pkg::*;

  localparam int ROW_MAX = (ROW_A > ROW_B) ? ROW_A : ROW_B;
  localparam int PRE_W   = (ROW_MAX > 2) ? $clog2(ROW_MAX) : 1;
  localparam logic [PRE_W-1:0] PONE = PRE_W'(1);
  localparam logic [EXP_W-1:0] EONE = EXP_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_last;
  logic [EXP_W-1:0] row_q;
  logic             row_wrap;

  assign pre_last = PRE_W'(row_cycles(dev_b, ROW_A, ROW_B) - 1);
  assign row_wrap = run && (pre_q == pre_last);
  assign last     = row_wrap && (row_q == exp_count - EONE);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      row_q <= '0;
    end else if (row_wrap) begin
      pre_q <= '0;
      row_q <= row_q + EONE;
    end else begin
      pre_q <= pre_q + PONE;
    end
  end
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 load_done,
  input  logic                 reset_done,
  input  logic                 exp_zero,
  input  logic                 exp_last,
  input  logic                 clr_missed,
  output pseq_pkg::phase_e     phase_q,
  output logic                 load_start_q,
  output logic                 reset_start_q,
  output logic                 missed_q
);
  import pseq_pkg::*;

  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (fire)       phase_d = PH_LOAD;
      PH_LOAD:   if (load_done)  phase_d = PH_RESET;
      PH_RESET:  if (reset_done) phase_d = exp_zero ? PH_IDLE : PH_EXPOSE;
      PH_EXPOSE: if (exp_last)   phase_d = PH_IDLE;
      default:                   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q       <= PH_IDLE;
      load_start_q  <= 1'b0;
      reset_start_q <= 1'b0;
      missed_q      <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      load_start_q  <= (phase_q == PH_IDLE) && fire;
      reset_start_q <= (phase_q == PH_LOAD) && load_done;
      if (fire && (phase_q != PH_IDLE)) missed_q <= 1'b1;
      else if (clr_missed)              missed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pattern_seq_top.sv
module pattern_seq_top #(
  parameter int          EXP_W    = 16,
  parameter int          IVAL_W   = 32,
  parameter int          ROW_A    = 20,
  parameter int          ROW_B    = 32,
  parameter int unsigned DEF_IVAL = 50000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        load_done,
  input  logic        reset_done,
  output logic        load_start,
  output logic        reset_start,
  output logic        busy,
  output logic [1:0]  phase,
  output logic        missed_trig
);
  import pseq_pkg::*;

  logic [EXP_W-1:0]  exp_q;
  logic [IVAL_W-1:0] ival_q;
  logic              dev_q;
  logic              ival_wr;
  logic              clr_missed;
  logic              exp_zero;
  logic              trig_fire;
  logic              exp_last;
  logic              expose_run;
  phase_e            phase_q;

  pseq_regs #(.EXP_W(EXP_W), .IVAL_W(IVAL_W), .DEF_IVAL(DEF_IVAL)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .exp_q(exp_q), .ival_q(ival_q), .dev_q(dev_q), .ival_wr(ival_wr),
    .clr_missed(clr_missed), .exp_zero(exp_zero)
  );

  pseq_trig_gen #(.IVAL_W(IVAL_W)) u_trig (
    .clk(clk), .rst(rst), .restart(ival_wr), .interval(ival_q), .fire(trig_fire)
  );

  assign expose_run = (phase_q == PH_EXPOSE);

  pseq_expose_timer #(.EXP_W(EXP_W), .ROW_A(ROW_A), .ROW_B(ROW_B)) u_expose (
    .clk(clk), .rst(rst), .run(expose_run), .dev_b(dev_q),
    .exp_count(exp_q), .last(exp_last)
  );

  pseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .fire(trig_fire), .load_done(load_done),
    .reset_done(reset_done), .exp_zero(exp_zero), .exp_last(exp_last),
    .clr_missed(clr_missed), .phase_q(phase_q), .load_start_q(load_start),
    .reset_start_q(reset_start), .missed_q(missed_trig)
  );

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] phase,
  input logic       load_start,
  input logic       reset_start,
  input logic       missed_trig,
  input logic       trig_fire,
  input logic       load_done,
  input logic       reset_done,
  input logic       exp_zero,
  input logic       clr_missed
);
  AST_IDLE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && !trig_fire) |=> (phase == 2'd0)); // R1
  AST_LOAD_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && !load_done) |=> (phase == 2'd1)); // R1
  AST_LOAD_START_EDGE: assert property (@(posedge clk) disable iff (rst)
    load_start |-> (phase == 2'd1 && $past(phase) == 2'd0)); // R2
  AST_RESET_START_EDGE: assert property (@(posedge clk) disable iff (rst)
    reset_start |-> (phase == 2'd2 && $past(phase) == 2'd1)); // R2
  AST_ZERO_SKIPS_EXPOSE: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && reset_done && exp_zero) |=> (phase == 2'd0)); // R3
  AST_DROP_SETS_MISSED: assert property (@(posedge clk) disable iff (rst)
    (trig_fire && phase != 2'd0) |=> missed_trig); // R7
  AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (rst)
    (missed_trig && !clr_missed) |=> missed_trig); // R7
endmodule

bind pattern_seq_top pseq_chk u_chk (
  .clk(clk), .rst(rst), .phase(phase), .load_start(load_start),
  .reset_start(reset_start), .missed_trig(missed_trig), .trig_fire(trig_fire),
  .load_done(load_done), .reset_done(reset_done), .exp_zero(exp_zero),
  .clr_missed(clr_missed)
);

// File: tb/test_pattern_seq_top.sv
module test_pattern_seq_top;
  localparam int DEF_IVAL = 50000;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        load_done;
  logic        reset_done;
  logic        load_start;
  logic        reset_start;
  logic        busy;
  logic [1:0]  phase;
  logic        missed_trig;

  always #4 clk = ~clk;

  pattern_seq_top i_pattern_seq_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .load_done(load_done), .reset_done(reset_done),
    .load_start(load_start), .reset_start(reset_start), .busy(busy),
    .phase(phase), .missed_trig(missed_trig)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R9";
  bit    cmp_on  = 0;
  int    ld_dly  = 3;
  int    rs_dly  = 2;

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model (behavioural) ----------------
  int     m_ph;
  bit     m_ls, m_rs, m_miss, m_dev;
  longint m_exp, m_ival, m_t, m_rem;

  always @(posedge clk) begin
    longint lim;
    bit     fire;
    if (rst) begin
      m_ph = 0; m_ls = 0; m_rs = 0; m_miss = 0; m_dev = 0;
      m_exp = 0; m_ival = DEF_IVAL; m_t = 0; m_rem = 0;
    end else begin
      lim  = (m_ival == 0) ? 1 : m_ival;
      fire = (m_t == lim - 1);
      m_t  = ((cfg_we && cfg_addr == 2'd1) || fire) ? 0 : m_t + 1;
      if (fire && m_ph != 0) m_miss = 1;
      else if (cfg_we && cfg_addr == 2'd3 && cfg_wdata[0]) m_miss = 0;
      m_ls = 0; m_rs = 0;
      case (m_ph)
        0: if (fire) begin m_ph = 1; m_ls = 1; end
        1: if (load_done) begin m_ph = 2; m_rs = 1; end
        2: if (reset_done) begin
             if (m_exp == 0) m_ph = 0;
             else begin m_ph = 3; m_rem = m_exp * (m_dev ? 32 : 20); end
           end
        default: begin m_rem--; if (m_rem == 0) m_ph = 0; end
      endcase
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_exp  = cfg_wdata & 32'h0000_FFFF;
          2'd1: m_ival = cfg_wdata;
          2'd2: m_dev  = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk(cur_req, "phase", phase, m_ph);
      chk(cur_req, "load_start", load_start, m_ls);
      chk(cur_req, "reset_start", reset_start, m_rs);
      chk("R8", "busy", busy, m_ph != 0);
      chk(cur_req, "missed_trig", missed_trig, m_miss);
    end
  end

  // ---------------- load / reset engines ----------------
  int lc = 0, rc = 0;
  always @(negedge clk) begin
    load_done  = 0;
    reset_done = 0;
    if (rst) begin
      lc = 0; rc = 0;
    end else begin
      if (lc > 0) begin lc--; if (lc == 0) load_done = 1; end
      if (rc > 0) begin rc--; if (rc == 0) reset_done = 1; end
      if (load_start)  lc = ld_dly;
      if (reset_start) rc = rs_dly;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_idle();
    while (phase != 2'd0) @(negedge clk);
  endtask

  task automatic wait_ls();
    do @(negedge clk); while (!load_start);
  endtask

  // one pass: EXPOSE cycle count, legal ordering, reset_start seen on RESET entry
  task automatic measure(output int n3, output bit ord_ok, output bit rs_ok);
    int prev;
    wait_ls();
    prev = 1; n3 = 0; ord_ok = 1; rs_ok = 0;
    do begin
      @(negedge clk);
      if (phase != prev) begin
        if (!((prev == 1 && phase == 2) || (prev == 2 && (phase == 3 || phase == 0)) ||
              (prev == 3 && phase == 0))) ord_ok = 0;
        if (phase == 2) rs_ok = reset_start;
        prev = phase;
      end
      if (phase == 3) n3++;
    end while (phase != 0);
  endtask

  task automatic period(output int p);
    wait_ls();
    p = 0;
    do begin @(negedge clk); p++; end while (!load_start);
  endtask

  initial begin
    int k, n3, p;
    bit ok, rs_ok;
    rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (4) @(negedge clk);
    chk("R9", "reset phase", phase, 0);
    chk("R9", "reset load_start", load_start, 0);
    chk("R9", "reset reset_start", reset_start, 0);
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset missed", missed_trig, 0);
    rst = 0; cmp_on = 1;

    cur_req = "R5";
    k = 0;
    do begin @(negedge clk); k++; end while (!load_start && k < 60000);
    chk("R5", "default first trigger delay", k, DEF_IVAL);
    wait_idle();

    cur_req = "R3";
    wr(2'd1, 100); wr(2'd2, 0); wr(2'd0, 0);
    measure(n3, ok, rs_ok);
    chk("R3", "expose cycles with count 0", n3, 0);
    chk("R1", "phase ordering", ok, 1);
    chk("R2", "reset_start on RESET entry", rs_ok, 1);

    cur_req = "R4";
    wr(2'd0, 2);
    measure(n3, ok, rs_ok);
    measure(n3, ok, rs_ok);
    chk("R4", "expose cycles type 0, count 2", n3, 40);
    chk("R1", "phase ordering with expose", ok, 1);
    wr(2'd2, 1);
    measure(n3, ok, rs_ok);
    measure(n3, ok, rs_ok);
    chk("R4", "expose cycles type 1, count 2", n3, 64);

    cur_req = "R10";
    wr(2'd2, 0); wr(2'd0, 32'h0001_0003);
    measure(n3, ok, rs_ok);
    measure(n3, ok, rs_ok);
    chk("R10", "upper exposure bits ignored", n3, 60);

    cur_req = "R6";
    wr(2'd0, 5); wr(2'd2, 1);
    wait_ls();
    period(p);
    period(p);
    chk("R6", "period snaps to 2 intervals", p, 200);
    @(negedge clk);
    chk("R7", "missed set after dropped trigger", missed_trig, 1);

    cur_req = "R7";
    wr(2'd1, 5000);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R7", "missed sticky", missed_trig, 1);
    wr(2'd3, 0);
    chk("R7", "write 0 does not clear", missed_trig, 1);
    wr(2'd3, 1);
    chk("R7", "write 1 clears", missed_trig, 0);

    cur_req = "R5";
    wr(2'd0, 0); wr(2'd1, 0);
    period(p);
    period(p);
    chk("R5", "interval 0 acts as 1", p, 8);

    cur_req = "R9";
    wr(2'd0, 5); wr(2'd1, 100);
    while (phase != 2'd3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R9", "mid-run reset phase", phase, 0);
    chk("R9", "mid-run reset busy", busy, 0);
    chk("R9", "mid-run reset missed", missed_trig, 0);
    rst = 0;
    k = 0;
    repeat (300) begin @(negedge clk); if (load_start) k++; end
    chk("R9", "interval back to default (no early trigger)", k, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule